// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Status

This block recovers characters from an asynchronous serial line. It is driven by a one-cycle strobe at sixteen times the bit rate, generated elsewhere. A falling line is treated as a possible start bit. The block confirms it at mid-bit, then takes each later bit at its centre. Word length, parity use, parity sense and forced ("stick") parity come from line-control fields. These are the same fields that configure the matching transmitter, and they must be held steady while a character is being received.

Every completed character is written into a receive buffer register. A five-bit status word holds the condition of that buffer and of the line: data ready, overrun, parity error, framing error and break. A read strobe on the buffer consumes the character. A read strobe on the status word clears the four error indications. The bus, baud generation and interrupt arbitration sit outside this block.

Top module: `uart_rx_core`

## Requirements
- R1: A start bit is detected on a tick that sees the line low. It is confirmed only if the line is still low on the 8th tick after detection. Otherwise the receiver returns to idle and no character is produced.
- R2: Data bits are sampled every 16 ticks after the start confirmation, least significant bit first, into the low bits of the buffer. The word length code maps 00 to 5 bits, 01 to 6, 10 to 7 and 11 to 8. Buffer bits above the word length read 0.
- R3: With parity enabled, one parity bit follows the data. The expected value depends on the parity fields. With odd/even select = 1 the total count of ones is even. With select = 0 the total count is odd. With stick set, the expected bit is the inverse of the odd/even select. A mismatch sets the parity-error flag.
- R4: Status bit 0 is data ready, bit 1 overrun, bit 2 parity error, bit 3 framing error and bit 4 break. Bits 7 to 5 always read 0. All status and buffer bits are 0 after reset.
- R5: Data ready is set when a character is written to the buffer. It is cleared by a buffer read strobe, unless a new character completes in the same cycle.
- R6: When a character completes while data ready is set and no buffer read is strobed in that cycle, the overrun flag is set and the new character replaces the buffer.
- R7: The framing-error flag is set when the stop bit samples as 0.
- R8: When every sample of a frame is 0, the break and framing-error flags are set and an all-zero character is stored. This covers start, data, parity if enabled, and stop. After any stop bit that samples 0, no new start is accepted until a tick sees the line high.
- R9: A status read strobe clears the overrun, parity, framing and break flags. A flag raised by a character completing in the same cycle is kept.
- R10: Buffer and status outputs change on the clock edge of the tick that samples the stop bit, and on the edge of a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | One-cycle strobe at 16x bit rate |
| wlen_i | input | 2 | Word length code (00 = 5 bits … 11 = 8 bits) |
| par_en_i | input | 1 | Parity bit present and checked |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| par_stick_i | input | 1 | Forced parity: expected bit = ~par_even_i |
| buf_rd_i | input | 1 | Buffer read strobe |
| stat_rd_i | input | 1 | Status read strobe |
| rbuf_o | output | 8 | Receive buffer |
| lstat_o | output | 8 | Line status word |

## Verification
Errors in the frame sequencer show up at the ports within one character time. A miscounted tick or bit index gives a wrong buffer value, or a spurious parity or framing error, on the edge of the stop-bit sample. A sequencer that fails to wait for a high line after a break produces a second all-zero character during the held break. Errors in the status register appear on the edge after the read strobe or completion that should have changed it. The reference model is compared against both output words on every clock, so any such divergence is flagged in the cycle it first appears.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        logic bi;
        logic fe;
        logic pe;
        logic oe;
        logic dr;
    } rx_flags_t;

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int OSR      = 16,
    parameter int MIN_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_i,
    input  logic              tick_i,
    input  logic [1:0]        wlen_i,
    input  logic              par_en_i,
    input  logic              par_even_i,
    input  logic              par_stick_i,
    output logic              commit_o,
    output logic [DATA_W-1:0] data_o,
    output logic              perr_o,
    output logic              ferr_o,
    output logic              brk_o
);

    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              pbit;
        logic              allz;
    } frm_t;

    frm_t frm_d, frm_q;

    logic [IDX_W-1:0] nbits;
    logic             last_bit;
    logic             exp_par;

    assign nbits    = IDX_W'(MIN_BITS) + IDX_W'(wlen_i);
    assign last_bit = (frm_q.idx == nbits - 1'b1);
    assign exp_par  = par_stick_i ? ~par_even_i
                    : (par_even_i ? ^frm_q.shreg : ~^frm_q.shreg);

    always_comb begin
        frm_d    = frm_q;
        commit_o = 1'b0;
        data_o   = frm_q.shreg;
        perr_o   = 1'b0;
        ferr_o   = 1'b0;
        brk_o    = 1'b0;
        if (tick_i) begin
            case (frm_q.state)
                RX_IDLE: begin
                    if (!rxd_i) begin
                        frm_d.state = RX_START;
                        frm_d.cnt   = '0;
                    end
                end
                RX_START: begin
                    if (frm_q.cnt == HALF) begin
                        frm_d.cnt = '0;
                        if (!rxd_i) begin
                            frm_d.state = RX_DATA;
                            frm_d.idx   = '0;
                            frm_d.shreg = '0;
                            frm_d.allz  = 1'b1;
                        end else begin
                            frm_d.state = RX_IDLE;
                        end
                    end else begin
                        frm_d.cnt = frm_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    frm_d.cnt = frm_q.cnt + 1'b1;
                    if (frm_q.cnt == FULL) begin
                        for (int i = 0; i < DATA_W; i++) begin
                            if (frm_q.idx == IDX_W'(i)) begin
                                frm_d.shreg[i] = rxd_i;
                            end
                        end
                        frm_d.allz = frm_q.allz & ~rxd_i;
                        frm_d.idx  = frm_q.idx + 1'b1;
                        if (last_bit) begin
                            frm_d.state = par_en_i ? RX_PAR : RX_STOP;
                        end
                    end
                end
                RX_PAR: begin
                    frm_d.cnt = frm_q.cnt + 1'b1;
                    if (frm_q.cnt == FULL) begin
                        frm_d.pbit  = rxd_i;
                        frm_d.allz  = frm_q.allz & ~rxd_i;
                        frm_d.state = RX_STOP;
                    end
                end
                RX_STOP: begin
                    frm_d.cnt = frm_q.cnt + 1'b1;
                    if (frm_q.cnt == FULL) begin
                        commit_o    = 1'b1;
                        ferr_o      = ~rxd_i;
                        brk_o       = frm_q.allz & ~rxd_i;
                        perr_o      = par_en_i & (frm_q.pbit != exp_par);
                        frm_d.state = rxd_i ? RX_IDLE : RX_HOLD;
                    end
                end
                RX_HOLD: begin
                    if (rxd_i) begin
                        frm_d.state = RX_IDLE;
                    end
                end
                default: frm_d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '{state: RX_IDLE, cnt: '0, idx: '0, shreg: '0,
                       pbit: 1'b0, allz: 1'b0};
        end else begin
            frm_q <= frm_d;
        end
    end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              perr_i,
    input  logic              ferr_i,
    input  logic              brk_i,
    input  logic              buf_rd_i,
    input  logic              stat_rd_i,
    output logic [DATA_W-1:0] rbuf_o,
    output rx_flags_t         flags_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rbuf;
        rx_flags_t         flags;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.rbuf     = commit_i ? data_i : st_q.rbuf;
        st_d.flags.dr = commit_i | (st_q.flags.dr & ~buf_rd_i);
        st_d.flags.oe = (st_q.flags.oe & ~stat_rd_i)
                      | (commit_i & st_q.flags.dr & ~buf_rd_i);
        st_d.flags.pe = (st_q.flags.pe & ~stat_rd_i) | (commit_i & perr_i);
        st_d.flags.fe = (st_q.flags.fe & ~stat_rd_i) | (commit_i & ferr_i);
        st_d.flags.bi = (st_q.flags.bi & ~stat_rd_i) | (commit_i & brk_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rbuf_o  = st_q.rbuf;
    assign flags_o = st_q.flags;

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int OSR      = 16,
    parameter int MIN_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_i,
    input  logic              tick16_i,
    input  logic [1:0]        wlen_i,
    input  logic              par_en_i,
    input  logic              par_even_i,
    input  logic              par_stick_i,
    input  logic              buf_rd_i,
    input  logic              stat_rd_i,
    output logic [DATA_W-1:0] rbuf_o,
    output logic [7:0]        lstat_o
);

    logic              frm_commit;
    logic [DATA_W-1:0] frm_data;
    logic              frm_perr;
    logic              frm_ferr;
    logic              frm_brk;
    rx_flags_t         flags;

    uart_rx_frame #(
        .DATA_W   (DATA_W),
        .OSR      (OSR),
        .MIN_BITS (MIN_BITS)
    ) frame_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rxd_i       (rxd_i),
        .tick_i      (tick16_i),
        .wlen_i      (wlen_i),
        .par_en_i    (par_en_i),
        .par_even_i  (par_even_i),
        .par_stick_i (par_stick_i),
        .commit_o    (frm_commit),
        .data_o      (frm_data),
        .perr_o      (frm_perr),
        .ferr_o      (frm_ferr),
        .brk_o       (frm_brk)
    );

    uart_rx_status #(
        .DATA_W (DATA_W)
    ) status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (frm_commit),
        .data_i    (frm_data),
        .perr_i    (frm_perr),
        .ferr_i    (frm_ferr),
        .brk_i     (frm_brk),
        .buf_rd_i  (buf_rd_i),
        .stat_rd_i (stat_rd_i),
        .rbuf_o    (rbuf_o),
        .flags_o   (flags)
    );

    assign lstat_o = {3'b000, flags.bi, flags.fe, flags.pe, flags.oe, flags.dr};

endmodule

module uart_rx_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       buf_rd_i,
    input logic       stat_rd_i,
    input logic [1:0] wlen_i,
    input logic       commit,
    input logic [4:0] stat5,
    input logic [2:0] rbuf_hi
);

    // R5
    dr_rise_needs_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat5[0]) |-> $past(commit));

    // R5
    dr_cleared_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd_i && !commit) |=> !stat5[0]);

    // R6
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && stat5[0] && !buf_rd_i) |=> stat5[1]);

    // R9
    errors_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !commit) |=> (stat5[4:1] == 4'b0000));

    // R2
    short_word_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && wlen_i == 2'b00) |=> (rbuf_hi == 3'b000));

    // R8
    break_implies_framing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat5[4] |-> stat5[3]);

endmodule

bind uart_rx_core uart_rx_core_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_rd_i  (buf_rd_i),
    .stat_rd_i (stat_rd_i),
    .wlen_i    (wlen_i),
    .commit    (frm_commit),
    .stat5     (lstat_o[4:0]),
    .rbuf_hi   (rbuf_o[DATA_W-1:DATA_W-3])
);

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] wlen = 2'b11;
    logic       pen = 1'b0;
    logic       peven = 1'b0;
    logic       pstick = 1'b0;
    logic       buf_rd = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rbuf;
    logic [7:0] lstat;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_rx_core dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rxd_i       (rxd),
        .tick16_i    (tick),
        .wlen_i      (wlen),
        .par_en_i    (pen),
        .par_even_i  (peven),
        .par_stick_i (pstick),
        .buf_rd_i    (buf_rd),
        .stat_rd_i   (stat_rd),
        .rbuf_o      (rbuf),
        .lstat_o     (lstat)
    );

    function automatic logic ref_par(logic [7:0] d, logic ev, logic st);
        if (st) return ~ev;
        return ev ? ^d : ~^d;
    endfunction

    // Behavioural reference model
    int         ms, tc, nb, bitn;
    logic [7:0] mdat, m_buf;
    logic       mpb, mzero;
    logic       m_dr, m_oe, m_pe, m_fe, m_bi;

    always @(posedge clk) begin
        logic c, cpe, cfe, cbi, old_dr;
        c = 0; cpe = 0; cfe = 0; cbi = 0;
        if (!rst_n) begin
            ms = 0; tc = 0; m_buf = 0;
            m_dr = 0; m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0;
        end else begin
            nb = 5 + int'(wlen);
            if (tick) begin
                case (ms)
                    0: if (!rxd) begin ms = 1; tc = 0; end
                    1: begin
                        tc++;
                        if (tc == 8) begin
                            if (!rxd) begin
                                ms = 2; tc = 0; bitn = 0; mdat = 0; mzero = 1;
                            end else ms = 0;
                        end
                    end
                    2: begin
                        tc++;
                        if (tc == 16) begin
                            tc = 0; mdat[bitn] = rxd; mzero = mzero & ~rxd; bitn++;
                            if (bitn == nb) ms = pen ? 3 : 4;
                        end
                    end
                    3: begin
                        tc++;
                        if (tc == 16) begin
                            tc = 0; mpb = rxd; mzero = mzero & ~rxd; ms = 4;
                        end
                    end
                    4: begin
                        tc++;
                        if (tc == 16) begin
                            c = 1; cfe = ~rxd; cbi = mzero & ~rxd;
                            cpe = pen && (mpb != ref_par(mdat, peven, pstick));
                            ms = rxd ? 0 : 5;
                        end
                    end
                    default: if (rxd) ms = 0;
                endcase
            end
            old_dr = m_dr;
            if (c) m_buf = mdat;
            m_dr = c | (m_dr & ~buf_rd);
            m_oe = (m_oe & ~stat_rd) | (c & old_dr & ~buf_rd);
            m_pe = (m_pe & ~stat_rd) | (c & cpe);
            m_fe = (m_fe & ~stat_rd) | (c & cfe);
            m_bi = (m_bi & ~stat_rd) | (c & cbi);
        end
    end

    // R10: clock-by-clock comparison of both outputs with the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (lstat !== {3'b000, m_bi, m_fe, m_pe, m_oe, m_dr} || rbuf !== m_buf) begin
                errors++;
                $display("FAIL R10 t=%0t stat=%02h/%02h exp=%02h/%02h", $time,
                         lstat, rbuf, {3'b000, m_bi, m_fe, m_pe, m_oe, m_dr}, m_buf);
            end
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick_n(int n);
        repeat (n) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic bit_out(logic v);
        rxd = v;
        tick_n(16);
    endtask

    task automatic frame(logic [7:0] d, logic pbit, logic stopv);
        bit_out(1'b0);
        for (int i = 0; i < 5 + int'(wlen); i++) bit_out(d[i]);
        if (pen) bit_out(pbit);
        bit_out(stopv);
        rxd = 1'b1;
        tick_n(3);
    endtask

    task automatic good_frame(logic [7:0] d);
        frame(d, ref_par(d & ((8'h1 << (5 + int'(wlen))) - 8'h1), peven, pstick), 1'b1);
    endtask

    task automatic rd_buf();
        @(negedge clk) buf_rd = 1'b1;
        @(negedge clk) buf_rd = 1'b0;
    endtask

    task automatic rd_stat();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 reset status", lstat, 8'h00);
        chk("R4 reset buffer", rbuf, 8'h00);

        wlen = 2'b11; pen = 0;
        good_frame(8'hA5);
        chk("R2 8-bit data", rbuf, 8'hA5);
        chk("R5 data ready set", lstat, 8'h01);
        rd_buf();
        chk("R5 data ready cleared", lstat, 8'h00);

        wlen = 2'b00;
        good_frame(8'hFF);
        chk("R2 5-bit upper zero", rbuf, 8'h1F);
        rd_buf();

        wlen = 2'b10; pen = 1; peven = 1;
        good_frame(8'h35);
        chk("R3 even parity ok", lstat, 8'h01);
        chk("R2 7-bit data", rbuf, 8'h35);
        rd_buf();

        peven = 0;
        frame(8'h35, ~ref_par(8'h35, 1'b0, 1'b0), 1'b1);
        chk("R3 odd parity wrong", lstat, 8'h05);
        rd_buf(); rd_stat();
        chk("R9 flags cleared", lstat, 8'h00);

        pstick = 1; wlen = 2'b11;
        frame(8'h3C, 1'b1, 1'b1);
        chk("R3 stick parity ok", lstat, 8'h01);
        rd_buf();
        frame(8'h3C, 1'b0, 1'b1);
        chk("R3 stick parity wrong", lstat, 8'h05);
        rd_buf(); rd_stat();
        pstick = 0; pen = 0;

        good_frame(8'h11);
        good_frame(8'h22);
        chk("R6 overrun flag", lstat, 8'h03);
        chk("R6 newest kept", rbuf, 8'h22);
        rd_stat();
        chk("R9 overrun cleared", lstat, 8'h01);
        rd_buf();

        frame(8'h5A, 1'b0, 1'b0);
        chk("R7 framing error", lstat, 8'h09);
        chk("R7 data stored", rbuf, 8'h5A);
        rd_buf(); rd_stat();

        rxd = 1'b0;
        tick_n(16 * 10 + 20);
        chk("R8 break flags", lstat, 8'h19);
        chk("R8 break zero data", rbuf, 8'h00);
        rd_buf();
        tick_n(200);
        chk("R8 no char while held low", lstat, 8'h18);
        rxd = 1'b1;
        tick_n(4);
        rd_stat();

        rxd = 1'b0;
        tick_n(4);
        rxd = 1'b1;
        tick_n(200);
        chk("R1 false start ignored", lstat, 8'h00);

        good_frame(8'hC3);
        chk("R1 receives after false start", rbuf, 8'hC3);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule